// File: doc/BRIEF.md
# Streaming Dataflow GCD Engine

This block computes the greatest common divisor of unsigned operand pairs. Operands come from two separate token streams, A and B, each with its own valid/ready handshake. The engine takes the i-th token of A together with the i-th token of B. Each result leaves on a third valid/ready stream.

The block is built as a small dataflow loop. A one-bit control token decides where the operand selectors take their values from. When the token is true, they take a fresh pair from the inputs. When it is false, they take the values fed back from the subtract step. On each pass, a step unit checks whether the two operands are equal. If they are not, it subtracts the smaller operand from the larger and sends the pair around the loop again.

When the operands are equal, operand A becomes the result and the control token turns true again. Only one pair is in flight at a time. A finished result waits in an output slot until the consumer takes it. Stalls on any port can change throughput, but never the values produced or their order.

Top module: `gcd_flow_engine`

## Requirements
- R1: A token is consumed on input A in a cycle exactly when a token is consumed on input B, so the i-th A token always pairs with the i-th B token.
- R2: After reset the output stream is not valid, and the control token is true. The first pair offered with both valids high is accepted (a_ready and b_ready read 1).
- R3: When the two operands of a pair are equal and nonzero, the result is that value, taken from operand A.
- R4: When both operands are nonzero and differ, the engine replaces the larger with the difference until the two are equal, and emits their greatest common divisor.
- R5: When exactly one operand is zero, the result is the other operand. When both are zero, the result is zero.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value on the next cycle.
- R7: No input pair is accepted while a result is waiting in the output slot or a pair is being reduced.
- R8: An input token whose partner stream has no valid token is never consumed. For A = 100, 56 and B = 45, 49, 3, the results are 5 then 7, and the B token 3 stays unconsumed with no further output.
- R9: The sequence of results is the same in order and value under any pattern of input gaps and output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | Stream A offers a token |
| a_ready | output | 1 | Stream A token is taken this cycle if valid |
| a_data | input | DATA_W | Stream A operand, unsigned |
| b_valid | input | 1 | Stream B offers a token |
| b_ready | output | 1 | Stream B token is taken this cycle if valid |
| b_data | input | DATA_W | Stream B operand, unsigned |
| out_valid | output | 1 | A result is available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DATA_W | Greatest common divisor of the pair |

## Verification
The assertions assume that each producer follows the normal handshake: once a token is offered, it is kept with its data unchanged until taken. They also assume that the consumer may lower out_ready at any time.

The bench drivers raise valid only between tokens. They keep each token on the port until the engine reports ready on that port. Randomness goes only into the gaps between tokens and into out_ready, never into withdrawing an offered token. Every result is compared in order against a software Euclid model, under two different stall profiles.

// File: rtl/gcd_flow_pkg.sv
// Package: shared types and defaults for the dataflow GCD engine.
// Assumes: nothing; pure declarations.
package gcd_flow_pkg;
    localparam int unsigned GCD_W_DEFAULT = 16;

    // Recirculating control token: true selects fresh inputs, false selects the feedback path.
    typedef enum logic {
        CTRL_FALSE = 1'b0,
        CTRL_TRUE  = 1'b1
    } ctrl_tok_e;
endpackage

// File: rtl/gcd_step.sv
// Module: gcd_step
// The combinational step of the loop. It decides whether the current operands are
// finished, picks the result, and forms the next pair by subtracting the
// smaller operand from the larger.
// Assumes: operands are unsigned. A zero operand ends the reduction at once.
module gcd_step #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] cur_a,
    input  logic [DATA_W-1:0] cur_b,
    output logic              finished,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] next_a,
    output logic [DATA_W-1:0] next_b
);
    logic a_zero;
    logic b_zero;
    logic a_bigger;

    // Equality, zero and magnitude tests on the current operands.
    always_comb begin
        a_zero   = (cur_a == '0);
        b_zero   = (cur_b == '0);
        a_bigger = (cur_a > cur_b);
        finished = (cur_a == cur_b) || a_zero || b_zero;
        result   = a_zero ? cur_b : cur_a;
    end

    // Replace the larger operand by the difference; keep the other unchanged.
    always_comb begin
        if (a_bigger) begin
            next_a = cur_a - cur_b;
            next_b = cur_b;
        end else begin
            next_a = cur_a;
            next_b = cur_b - cur_a;
        end
    end
endmodule

// File: rtl/gcd_steer.sv
// Module: gcd_steer
// Holds the control token and the operand registers. A true token takes a
// fresh pair from both input streams together. A false token reloads the
// operands from the step unit's feedback until the step reports it is finished.
// Assumes: accept_ok is low while a result is pending downstream.
module gcd_steer
    import gcd_flow_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_ok,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_valid,
    input  logic [DATA_W-1:0] b_data,
    input  logic              step_finished,
    input  logic [DATA_W-1:0] loop_a,
    input  logic [DATA_W-1:0] loop_b,
    output logic              a_ready,
    output logic              b_ready,
    output logic              reducing,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    ctrl_tok_e token_q;
    logic      take_pair;

    // Ready on each side only when the partner stream is also valid.
    always_comb begin
        a_ready   = (token_q == CTRL_TRUE) && accept_ok && b_valid;
        b_ready   = (token_q == CTRL_TRUE) && accept_ok && a_valid;
        take_pair = (token_q == CTRL_TRUE) && accept_ok && a_valid && b_valid;
        reducing  = (token_q == CTRL_FALSE);
    end

    // Token update: cleared on a fresh pair, set again once the step is finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token_q <= CTRL_TRUE;
        end else if (take_pair) begin
            token_q <= CTRL_FALSE;
        end else if (reducing && step_finished) begin
            token_q <= CTRL_TRUE;
        end
    end

    // Operand selectors: inputs under a true token, feedback under a false one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else if (take_pair) begin
            op_a <= a_data;
            op_b <= b_data;
        end else if (reducing && !step_finished) begin
            op_a <= loop_a;
            op_b <= loop_b;
        end
    end
endmodule

// File: rtl/gcd_out_slot.sv
// Module: gcd_out_slot
// Single-entry output register. It captures a result and keeps it valid until
// the consumer is ready.
// Assumes: load is never raised while the slot is full.
module gcd_out_slot #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Fill on load, empty on a completed output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/gcd_flow_engine.sv
// Module: gcd_flow_engine (top)
// Streaming GCD engine. It pairs tokens from streams A and B, reduces them by
// repeated subtraction in a token-controlled loop, and emits one result per pair.
// Assumes: one pair in flight at a time. Producers hold an offered token until it is taken.
module gcd_flow_engine
    import gcd_flow_pkg::*;
#(
    parameter int unsigned DATA_W = GCD_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [DATA_W-1:0] b_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              reducing;
    logic              finished;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] nxt_a;
    logic [DATA_W-1:0] nxt_b;
    logic [DATA_W-1:0] result;
    logic              accept_ok;
    logic              emit;

    // New pairs only when the output slot is empty; emit when the loop finishes.
    always_comb begin
        accept_ok = !out_valid;
        emit      = reducing && finished;
    end

    gcd_steer #(.DATA_W(DATA_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .accept_ok(accept_ok),
        .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
        .step_finished(finished), .loop_a(nxt_a), .loop_b(nxt_b),
        .a_ready(a_ready), .b_ready(b_ready), .reducing(reducing),
        .op_a(op_a), .op_b(op_b)
    );

    gcd_step #(.DATA_W(DATA_W)) u_step (
        .cur_a(op_a), .cur_b(op_b), .finished(finished),
        .result(result), .next_a(nxt_a), .next_b(nxt_b)
    );

    gcd_out_slot #(.DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(emit), .load_data(result),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/gcd_flow_engine_chk.sv
// Module: gcd_flow_engine_chk
// Port-level protocol checks for gcd_flow_engine, attached by bind.
// Assumes: producers hold offered tokens stable until they are taken.
module gcd_flow_engine_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_valid,
    input logic              a_ready,
    input logic              b_valid,
    input logic              b_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    AST_PAIRED_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) == (b_valid && b_ready)); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(a_valid && a_ready)); // R7
    AST_LONE_B_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !a_valid |-> !b_ready); // R8
    AST_LONE_A_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !b_valid |-> !a_ready); // R8
endmodule

bind gcd_flow_engine gcd_flow_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_ready(a_ready),
    .b_valid(b_valid), .b_ready(b_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
);

// File: tb/gcd_flow_engine_tb.sv
// Bench: vector table under random throttling, then directed tests.
module gcd_flow_engine_tb;
    localparam int W = 16;
    localparam int NV = 10;
    // Each entry is {a, b}.
    localparam logic [31:0] VEC [0:NV-1] = '{
        {16'd12, 16'd18}, {16'd9, 16'd9}, {16'd0, 16'd7}, {16'd21, 16'd0},
        {16'd0, 16'd0}, {16'd1, 16'd1000}, {16'd65535, 16'd65534},
        {16'd270, 16'd192}, {16'd17, 16'd13}, {16'd1024, 16'd4096}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 1'b0, b_valid = 1'b0, out_ready = 1'b0;
    logic [W-1:0] a_data = '0, b_data = '0;
    logic a_ready, b_ready, out_valid;
    logic [W-1:0] out_data;

    int checks = 0, failures = 0;
    int a_q [0:15];
    int b_q [0:15];
    int exp_q [0:15];
    string exp_tag [0:15];
    int exp_n = 0, got_n = 0;
    bit mon_en = 1'b0;
    int rdy_pct = 100;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gcd_flow_engine #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic int sw_gcd(input int x, input int y);
        int p = x, q = y, t;
        while (q != 0) begin t = p % q; p = q; q = t; end
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Output monitor: random ready, in-order compare against the model.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) out_ready = (($urandom % 100) < rdy_pct);
            #1;
            if (mon_en && out_valid && out_ready) begin
                chk(got_n < exp_n && out_data == exp_q[got_n[3:0]],
                    exp_tag[got_n[3:0]], out_data, exp_q[got_n[3:0]]);
                got_n++;
            end
        end
    end

    task automatic drive_a(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            while (($urandom % 100) < gap) @(negedge clk);
            a_valid = 1'b1; a_data = a_q[i][W-1:0];
            forever begin #1; if (a_ready) break; @(negedge clk); end
            @(negedge clk); a_valid = 1'b0;
        end
    endtask

    task automatic drive_b(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            while (($urandom % 100) < gap) @(negedge clk);
            b_valid = 1'b1; b_data = b_q[i][W-1:0];
            forever begin #1; if (b_ready) break; @(negedge clk); end
            @(negedge clk); b_valid = 1'b0;
        end
    endtask

    task automatic run_table(input int gap, input int rp, input string extra);
        exp_n = NV; got_n = 0; rdy_pct = rp;
        for (int i = 0; i < NV; i++) begin
            a_q[i] = int'(VEC[i][31:16]); b_q[i] = int'(VEC[i][15:0]);
            exp_q[i] = sw_gcd(a_q[i], b_q[i]);
            if (a_q[i] == 0 || b_q[i] == 0) exp_tag[i] = {"R5 ", extra};
            else if (a_q[i] == b_q[i]) exp_tag[i] = {"R3 ", extra};
            else exp_tag[i] = {"R4 ", extra};
        end
        mon_en = 1'b1;
        fork
            drive_a(NV, gap);
            drive_b(NV, gap);
        join
        wait (got_n == exp_n);
        @(negedge clk);
        mon_en = 1'b0; out_ready = 1'b0;
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", got_n, exp_n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: empty output after reset, fresh token accepts a pair
        chk(out_valid == 1'b0, "R2 out_valid", out_valid, 0);
        a_valid = 1'b1; b_valid = 1'b1; #1;
        chk(a_ready && b_ready, "R2 ready", {a_ready, b_ready}, 3);
        a_valid = 1'b0; b_valid = 1'b0;

        // R3 R4 R5 R9: table under heavy random throttling
        @(negedge clk);
        run_table(40, 50, "throttled");

        // R8: example with an unpartnered B token
        exp_n = 2; got_n = 0; rdy_pct = 100;
        a_q[0] = 100; a_q[1] = 56; b_q[0] = 45; b_q[1] = 49;
        exp_q[0] = 5; exp_q[1] = 7; exp_tag[0] = "R8 first"; exp_tag[1] = "R8 second";
        mon_en = 1'b1;
        fork
            drive_a(2, 0);
            drive_b(2, 0);
        join
        b_valid = 1'b1; b_data = 16'd3;
        wait (got_n == exp_n);
        begin
            int stray = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk); #1;
                if (b_ready || out_valid) stray++;
            end
            chk(stray == 0, "R8 lone token kept", stray, 0);
        end
        b_valid = 1'b0; mon_en = 1'b0; out_ready = 1'b0;

        // R6 R7: result held while stalled, no new pair taken
        @(negedge clk);
        a_valid = 1'b1; a_data = 16'd8; b_valid = 1'b1; b_data = 16'd12;
        @(negedge clk);
        a_data = 16'd3; b_data = 16'd3;
        begin
            int guard = 0;
            while (!out_valid && guard < 50) begin @(negedge clk); guard++; end
        end
        begin
            int bad_hold = 0, bad_acc = 0;
            for (int k = 0; k < 8; k++) begin
                #1;
                if (!out_valid || out_data != 16'd4) bad_hold++;
                if (a_ready || b_ready) bad_acc++;
                @(negedge clk);
            end
            chk(bad_hold == 0, "R6 hold", bad_hold, 0);
            chk(bad_acc == 0, "R7 no accept", bad_acc, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        // Pending pair 3,3 is now taken; wait for its result.
        begin
            int guard = 0;
            #1;
            while (!(a_valid && a_ready) && guard < 10) begin @(negedge clk); #1; guard++; end
            @(negedge clk);
            a_valid = 1'b0; b_valid = 1'b0;
            guard = 0;
            while (!out_valid && guard < 50) begin @(negedge clk); guard++; end
            #1;
            chk(out_valid && out_data == 16'd3, "R3 after stall", out_data, 3);
        end
        @(negedge clk);
        out_ready = 1'b0;

        // R9: same table, no gaps and output always ready
        @(negedge clk);
        run_table(0, 100, "R9 free-running");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule